// File: doc/BRIEF.md
# Dual-Edge Column Data Packer

This block sits between a pixel source and a row of column drivers that latch on both edges of a forwarded clock. It accepts one 6-bit red, green and blue value per pixel period and spreads each colour over three narrow lanes. Each lane carries two bits per pixel period: one while the lane clock is high and one while it is low. Nine data lanes and one clock lane leave the block in total.

The block runs from a single fast clock. A pixel period is `FAST_PER_PIX` fast cycles long, so the two edges of the lane clock fall on ordinary fast-clock boundaries. The pixel stream is held back inside the block so that a one-period column start pulse appears exactly two pixel periods before the first active pixel of a line reaches the lanes. A 3-bit skew input delays the lane data by a chosen number of fast cycles relative to the lane clock. This shifts setup against hold at the receiver.

Top module: `ddp_column_packer`

## Requirements
- R1: Count clk rising edges after reset release as 1, 2, 3 and so on. The state after edge n belongs to pixel period floor(n/16) at phase n mod 16. `lane_clk` is 1 at phases 0 to 7 and 0 at phases 8 to 15, and it keeps toggling this way for as long as reset is released.
- R2: The pixel inputs (`pix_de`, `pix_r`, `pix_g`, `pix_b`) are sampled only on the last edge of each pixel period. Values that are present earlier in the period and replaced before that edge have no effect on the lanes.
- R3: Lane k of each colour (k = 0, 1, 2, index k of `lane_r`/`lane_g`/`lane_b`) carries colour bit 2k while `lane_clk` is high.
- R4: `col_start` is 1 for exactly the pixel period that follows the period in which `pix_de` went from 0 to 1. It is 0 in every other period, and it changes only at phase 0.
- R5: The pixel presented in period p appears on the lanes in period p+3 when the skew is 0. In the low half of that period, lane k of each colour carries colour bit 2k+1.
- R6: In any period whose pixel (three periods earlier) had `pix_de` = 0, all nine lanes are 0 when the skew is 0.
- R7: A `skew_sel` value s delays all nine lanes by s fast cycles relative to `lane_clk` (0 to 7). The delay applies to the lane values of the undelayed stream, so lanes show 0 for data from before reset release.
- R8: While `rst_n` is 0, all lanes and `col_start` are 0 and `lane_clk` is 1.
- R9: Each new 0-to-1 transition of `pix_de` produces a new start pulse. This holds after a blank gap of a single period and for lines only one pixel long. No pulse occurs while `pix_de` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, 16 cycles per pixel period |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_de | input | 1 | Active pixel flag for the current period |
| pix_r | input | 6 | Red value |
| pix_g | input | 6 | Green value |
| pix_b | input | 6 | Blue value |
| skew_sel | input | 3 | Data delay in fast cycles relative to the lane clock |
| lane_r | output | 3 | Red data lanes |
| lane_g | output | 3 | Green data lanes |
| lane_b | output | 3 | Blue data lanes |
| lane_clk | output | 1 | Forwarded lane clock |
| col_start | output | 1 | Column start pulse, one pixel period wide |

## Verification
The start pulse for a new line and the last pixels of the previous line can share a pixel period: with a one-period blanking gap, `col_start` is high while the lanes still carry the tail of the previous line. Changing `skew_sel` at a line boundary also lets delayed data from one setting overlap the clock edges under the next setting. The bench provokes both with single-period gaps, single-pixel lines and per-line skew changes. It judges every fast cycle against a model that derives each lane bit from the stored input history, shifted by the skew currently applied.

// File: rtl/ddp_pkg.sv
// Shared definitions for the dual-edge column data packer.
// Assumes an even colour width so that every lane carries exactly two bits.
package ddp_pkg;
    localparam int COLOR_W         = 6;
    localparam int LANES_PER_COLOR = COLOR_W / 2;
    localparam int LANES_TOTAL     = 3 * LANES_PER_COLOR;

    typedef struct packed {
        logic               de;
        logic [COLOR_W-1:0] r;
        logic [COLOR_W-1:0] g;
        logic [COLOR_W-1:0] b;
    } pix_t;
endpackage

// File: rtl/ddp_phase_gen.sv
// Phase counter for one pixel period made of FAST_PER_PIX fast cycles.
// Provides the end-of-period strobe and the lane clock level (high in the first half).
// Assumes FAST_PER_PIX is even and at least 4.
module ddp_phase_gen #(
    parameter int FAST_PER_PIX = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    output logic [$clog2(FAST_PER_PIX)-1:0] phase,
    output logic                            pix_end,
    output logic                            first_half
);
    localparam int PW   = $clog2(FAST_PER_PIX);
    localparam int HALF = FAST_PER_PIX / 2;

    assign pix_end    = (phase == PW'(FAST_PER_PIX - 1));
    assign first_half = (phase < PW'(HALF));

    // Advance the phase every fast cycle, wrapping at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (pix_end) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/ddp_align_pipe.sv
// Holds back the pixel stream by DEPTH pixel periods and derives the column start pulse
// from the rising edge of the active flag, so the pulse leads the first pixel by DEPTH-1
// periods. Assumes adv pulses once per pixel period, on its last fast cycle.
module ddp_align_pipe
    import ddp_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  pix_t pix_in,
    output pix_t pix_out,
    output logic start
);
    pix_t stg [DEPTH];

    // Shift the pixel delay line and register the line start once per period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
            start <= 1'b0;
        end else if (adv) begin
            stg[0] <= pix_in;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
            start <= pix_in.de & ~stg[0].de;
        end
    end

    assign pix_out = stg[DEPTH-1];

    // R4: a start pulse always accompanies a freshly captured active pixel
    p_start_marks_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> stg[0].de);

    // R4: the pulse never spans two consecutive pixel periods
    p_start_one_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && start) |=> !start);
endmodule

// File: rtl/ddp_lane_ser.sv
// Splits one aligned pixel into per-lane bits for the high and low halves of the lane clock,
// blanks them outside active data, and delays the result by 0 to SKEW_TAPS-1 fast cycles.
// Assumes SKEW_TAPS is at least 2 and the skew select stays below SKEW_TAPS.
module ddp_lane_ser
    import ddp_pkg::*;
#(
    parameter int SKEW_TAPS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         first_half,
    input  pix_t                         pix,
    input  logic [$clog2(SKEW_TAPS)-1:0] skew,
    output logic [LANES_PER_COLOR-1:0]   lane_r,
    output logic [LANES_PER_COLOR-1:0]   lane_g,
    output logic [LANES_PER_COLOR-1:0]   lane_b
);
    localparam int L  = LANES_PER_COLOR;
    localparam int LW = LANES_TOTAL;

    logic [LW-1:0] hi_bits;
    logic [LW-1:0] lo_bits;
    logic [LW-1:0] now_bits;
    logic [LW-1:0] dly [1:SKEW_TAPS-1];
    logic [LW-1:0] sel_bits;

    // Lane k takes the even bit 2k in the high half and the odd bit 2k+1 in the low half.
    for (genvar k = 0; k < L; k++) begin : g_map
        assign hi_bits[k]       = pix.r[2*k];
        assign lo_bits[k]       = pix.r[2*k+1];
        assign hi_bits[L+k]     = pix.g[2*k];
        assign lo_bits[L+k]     = pix.g[2*k+1];
        assign hi_bits[2*L+k]   = pix.b[2*k];
        assign lo_bits[2*L+k]   = pix.b[2*k+1];
    end

    // Choose the half-cycle bit and force zeros during blanking.
    always_comb begin
        now_bits = '0;
        if (pix.de) now_bits = first_half ? hi_bits : lo_bits;
    end

    // Fast-cycle delay line used for setup/hold trimming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i < SKEW_TAPS; i++) dly[i] <= '0;
        end else begin
            dly[1] <= now_bits;
            for (int i = 2; i < SKEW_TAPS; i++) dly[i] <= dly[i-1];
        end
    end

    // Pick the tap named by the skew setting.
    always_comb begin
        if (skew == '0) sel_bits = now_bits;
        else            sel_bits = dly[skew];
    end

    assign lane_r = sel_bits[L-1:0];
    assign lane_g = sel_bits[2*L-1:L];
    assign lane_b = sel_bits[3*L-1:2*L];
endmodule

// File: rtl/ddp_column_packer.sv
// Top of the dual-edge column data packer: phase generation, start alignment and lane
// serialisation. Assumes pixel inputs are held for a whole pixel period and sampled at its end.
module ddp_column_packer #(
    parameter int FAST_PER_PIX = 16,
    parameter int START_LEAD   = 2,
    parameter int SKEW_TAPS    = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  pix_de,
    input  logic [ddp_pkg::COLOR_W-1:0]           pix_r,
    input  logic [ddp_pkg::COLOR_W-1:0]           pix_g,
    input  logic [ddp_pkg::COLOR_W-1:0]           pix_b,
    input  logic [$clog2(SKEW_TAPS)-1:0]          skew_sel,
    output logic [ddp_pkg::LANES_PER_COLOR-1:0]   lane_r,
    output logic [ddp_pkg::LANES_PER_COLOR-1:0]   lane_g,
    output logic [ddp_pkg::LANES_PER_COLOR-1:0]   lane_b,
    output logic                                  lane_clk,
    output logic                                  col_start
);
    import ddp_pkg::*;

    localparam int ALIGN_DEPTH = START_LEAD + 1;
    localparam int PW          = $clog2(FAST_PER_PIX);

    logic [PW-1:0] phase;
    logic          pix_end;
    logic          first_half;
    pix_t          in_pix;
    pix_t          aligned;

    assign in_pix = {pix_de, pix_r, pix_g, pix_b};

    ddp_phase_gen #(.FAST_PER_PIX(FAST_PER_PIX)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .pix_end    (pix_end),
        .first_half (first_half)
    );

    ddp_align_pipe #(.DEPTH(ALIGN_DEPTH)) u_align (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (pix_end),
        .pix_in  (in_pix),
        .pix_out (aligned),
        .start   (col_start)
    );

    ddp_lane_ser #(.SKEW_TAPS(SKEW_TAPS)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .first_half (first_half),
        .pix        (aligned),
        .skew       (skew_sel),
        .lane_r     (lane_r),
        .lane_g     (lane_g),
        .lane_b     (lane_b)
    );

    assign lane_clk = first_half;

    // R1: the lane clock rises right after every period end
    p_clk_rise_at_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pix_end |=> $rose(lane_clk));

    // R4: the start pulse only begins on a pixel period boundary
    p_start_on_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_start) |-> (phase == '0));
endmodule

// File: tb/ddp_column_packer_tb.sv
module ddp_column_packer_tb;
    localparam int N    = 16;
    localparam int HALF = N / 2;
    localparam int NS   = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_de = 1'b0;
    logic [5:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic [2:0] skew_sel = '0;
    logic [2:0] lane_r, lane_g, lane_b;
    logic       lane_clk, col_start;

    ddp_column_packer u_dut (
        .clk(clk), .rst_n(rst_n), .pix_de(pix_de), .pix_r(pix_r), .pix_g(pix_g),
        .pix_b(pix_b), .skew_sel(skew_sel), .lane_r(lane_r), .lane_g(lane_g),
        .lane_b(lane_b), .lane_clk(lane_clk), .col_start(col_start)
    );

    always #2 clk = ~clk;

    bit         pde [0:NS-1];
    logic [5:0] pr  [0:NS-1];
    logic [5:0] pg  [0:NS-1];
    logic [5:0] pb  [0:NS-1];
    bit         dec [0:NS-1];
    logic [2:0] sk  [0:NS-1];
    int  first_line = 0;
    int  cyc = 0;
    int  n_chk = 0, n_bad = 0;
    bit  done = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Undelayed lane word {b,g,r} expected at fast cycle c.
    function automatic logic [8:0] undel(int c);
        logic [8:0] v;
        int j;
        bit hi;
        v = '0;
        if (c < 0) return v;
        j = c / N - 3;
        if (j < 0 || !pde[j]) return v;
        hi = (c % N) < HALF;
        for (int l = 0; l < 3; l++) begin
            v[l]   = hi ? pr[j][2*l] : pr[j][2*l+1];
            v[3+l] = hi ? pg[j][2*l] : pg[j][2*l+1];
            v[6+l] = hi ? pb[j][2*l] : pb[j][2*l+1];
        end
        return v;
    endfunction

    function automatic bit exp_start(int k);
        bit a, b;
        a = (k >= 1) ? pde[k-1] : 1'b0;
        b = (k >= 2) ? pde[k-2] : 1'b0;
        return a && !b;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    // Build the stimulus: directed lines first, then random lines and gaps.
    initial begin
        int k, len, gap, line;
        logic [2:0] s;
        void'($urandom(32'd4711));
        for (int i = 0; i < NS; i++) begin
            pde[i] = 0; pr[i] = '0; pg[i] = '0; pb[i] = '0; dec[i] = 0; sk[i] = '0;
        end
        k = 6; line = 0;
        first_line = k;
        while (k < NS - 12) begin
            if (line == 0)      begin len = 1; gap = 3; s = 3'd0; end
            else if (line == 1) begin len = 4; gap = 1; s = 3'd0; end
            else if (line == 2) begin len = 1; gap = 1; s = 3'd0; end
            else begin
                len = 1 + int'($urandom % 24);
                gap = 1 + int'($urandom % 5);
                s   = 3'($urandom % 8);
            end
            for (int p = 0; p < len; p++) begin
                pde[k] = 1;
                if (line == 0) begin
                    pr[k] = 6'h3F; pg[k] = 6'h3F; pb[k] = 6'h3F;
                end else if (line == 1) begin
                    pr[k] = p[0] ? 6'h15 : 6'h2A; pg[k] = p[0] ? 6'h2A : 6'h15;
                    pb[k] = 6'h01 << p;
                end else begin
                    pr[k] = 6'($urandom); pg[k] = 6'($urandom); pb[k] = 6'($urandom);
                    dec[k] = ($urandom % 4) == 0;
                end
                sk[k] = s; k++;
            end
            for (int p = 0; p < gap; p++) begin
                sk[k] = s; dec[k] = (line > 2) && (($urandom % 4) == 0); k++;
            end
            line++;
        end
    end

    // Apply slot values: decoy first in marked slots, the real value by mid-period.
    task automatic apply(int k, bit decoy);
        if (decoy) begin
            pix_de = 1'($urandom); pix_r = 6'($urandom); pix_g = 6'($urandom); pix_b = 6'($urandom);
        end else begin
            pix_de = pde[k]; pix_r = pr[k]; pix_g = pg[k]; pix_b = pb[k];
        end
    endtask

    initial begin
        rst_n = 1'b0;
        apply(0, 1'b0);
        repeat (6) @(posedge clk);
        #1 rst_n = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            if (cyc >= NS * N) begin
                done = 1'b1;
                break;
            end
            if (cyc % N == 0) begin
                skew_sel = sk[cyc / N];
                apply(cyc / N, dec[cyc / N]);
            end else if (cyc % N == HALF && dec[cyc / N]) begin
                apply(cyc / N, 1'b0);
            end
        end
    end

    // Compare every fast cycle against the model, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                check("R8", {23'd0, lane_b, lane_g, lane_r}, 32'd0);
                check("R8", {31'd0, col_start}, 32'd0);
                check("R8", {31'd0, lane_clk}, 32'd1);
            end else begin
                int c, k, s, j;
                string tag;
                c = cyc; k = c / N;
                s = int'(sk[(k < NS) ? k : NS - 1]);
                check("R1", {31'd0, lane_clk}, {31'd0, ((c % N) < HALF)});
                tag = (k - 1 > first_line) ? "R9" : "R4";
                check(tag, {31'd0, col_start}, {31'd0, exp_start(k)});
                j = (c - s) / N - 3;
                if (s != 0)                                 tag = "R7";
                else if (j < 0 || !pde[j])                  tag = "R6";
                else if (dec[j])                            tag = "R2";
                else if ((c % N) < HALF)                    tag = "R3";
                else                                        tag = "R5";
                check(tag, {23'd0, lane_b, lane_g, lane_r}, {23'd0, undel(c - s)});
            end
        end
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                #(4 * 150000);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual running expected finished");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule